// File: doc/BRIEF.md
# Multiplexed-Address Strobe to Static RAM Bridge

This block lets a memory controller designed for row/column multiplexed dynamic RAM drive a 16-bit static RAM that has separate lower and upper byte selects. The controller supplies a 9-bit shared address bus, an active-low row strobe, an active-low column strobe and two active-low write enables, one for each 8-bit bank. The bridge rebuilds the 18-bit word address and produces the static RAM's write enable, output enable and two byte selects.

All four strobes are brought into a fast system clock domain through two-flop synchronisers. Falling edges of the row and column strobes are found on the synchronised copies, and the matching bus half is taken from a bus sample that has been delayed to line up with the strobes. Writes go byte by byte, steered by the bank write enables. A read delivers a 16-bit word as two byte halves: the lower byte while the column strobe is low and the upper byte once it returns high.

Top module: `dram_sram_bridge`

## Requirements
- R1: While rst_ni is low, sram_we_no, sram_oe_no, sram_lb_no and sram_ub_no are all 1 and sram_addr_o is zero.
- R2: A falling edge of ras_ni loads the bus value present at that edge into sram_addr_o[17:9]; the output changes on the third rising clock edge after the strobe edge is sampled.
- R3: A falling edge of cas_ni loads the bus value present at that edge into sram_addr_o[8:0]; bus changes, and rising strobe edges, leave sram_addr_o unchanged.
- R4: sram_we_no is 0 exactly when we0_ni or we1_ni is 0, three clock edges after the input is sampled.
- R5: Out of reset, sram_oe_no is always the inverse of sram_we_no.
- R6: During a write, sram_lb_no equals we0_ni and sram_ub_no equals we1_ni; with both enables low, both selects are 0.
- R7: During a read, sram_lb_no equals cas_ni and sram_ub_no equals the inverse of cas_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the strobe rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| maddr_i | input | 9 | Multiplexed row/column address bus |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we0_ni | input | 1 | Lower bank write enable, active low |
| we1_ni | input | 1 | Upper bank write enable, active low |
| sram_addr_o | output | 18 | Rebuilt word address, row in [17:9], column in [8:0] |
| sram_we_no | output | 1 | Static RAM write enable, active low |
| sram_oe_no | output | 1 | Static RAM output enable, active low |
| sram_lb_no | output | 1 | Lower byte select, active low |
| sram_ub_no | output | 1 | Upper byte select, active low |

## Verification
The assertions assume each strobe level is held for several system clocks and that the address bus is steady on the clock edges around a strobe fall, so the delayed bus sample and the synchronised strobe describe the same moment. They also assume every input was high while reset was held. The stimulus drives inputs only on falling clock edges, keeps each level for five clocks, changes the bus only while no strobe edge is pending, and asserts write enables only inside a column strobe. Random rows, columns and write masks, including both banks at once, are mixed with directed corner addresses.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef struct packed {
    logic we_n;
    logic oe_n;
    logic lb_n;
    logic ub_n;
  } sram_ctl_t;

  localparam sram_ctl_t CTL_IDLE = '{we_n: 1'b1, oe_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1};

  // strobe vector positions
  localparam int unsigned STB_RAS = 0;
  localparam int unsigned STB_CAS = 1;
  localparam int unsigned STB_WE0 = 2;
  localparam int unsigned STB_WE1 = 3;
  localparam int unsigned STB_NUM = 4;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned N_EDGE = 2,
  parameter int unsigned LVL_LO = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:LVL_LO] level_o,
  output logic [N_EDGE-1:0] fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [N-1:0] synced;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], raw_i[i]};
    end
    assign synced[i] = sh_q[LAST];
  end

  for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= synced[i];
    end
    assign fall_o[i] = prev_q & ~synced[i];
  end

  assign level_o = synced[N-1:LVL_LO];
endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int unsigned BUS_W  = 9,
  parameter int unsigned STAGES = 2,
  localparam int unsigned ADDR_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              row_fall_i,
  input  logic              col_fall_i,
  output logic [ADDR_W-1:0] addr_o
);
  // delay the bus by the synchroniser depth so it matches the strobe copy
  logic [BUS_W-1:0] dly_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q[s] <= '0;
      else if (s == 0) dly_q[s] <= bus_i;
      else             dly_q[s] <= dly_q[(s == 0) ? 0 : s-1];
    end
  end

  logic [BUS_W-1:0] row_q, col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (row_fall_i) row_q <= dly_q[STAGES-1];
      if (col_fall_i) col_q <= dly_q[STAGES-1];
    end
  end

  assign addr_o = {row_q, col_q};
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import bridge_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cas_i,
  input  logic      we0_i,
  input  logic      we1_i,
  output sram_ctl_t ctl_o
);
  sram_ctl_t ctl_d, ctl_q;
  logic      idle_wr;

  always_comb begin
    idle_wr    = we0_i & we1_i;
    ctl_d.we_n = idle_wr;
    ctl_d.oe_n = ~idle_wr;
    // writes steer lanes by bank; reads split the word over the cas phases
    ctl_d.lb_n = idle_wr ? cas_i  : we0_i;
    ctl_d.ub_n = idle_wr ? ~cas_i : we1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_IDLE;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned BUS_W  = 9,
  parameter int unsigned STAGES = 2,
  localparam int unsigned ADDR_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  maddr_i,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we0_ni,
  input  logic              we1_ni,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic              sram_lb_no,
  output logic              sram_ub_no
);
  logic [STB_NUM-1:0]       raw;
  logic [STB_NUM-1:STB_CAS] lvl;
  logic [STB_CAS:STB_RAS]   fall;
  sram_ctl_t                ctl;

  always_comb begin
    raw          = '1;
    raw[STB_RAS] = ras_ni;
    raw[STB_CAS] = cas_ni;
    raw[STB_WE0] = we0_ni;
    raw[STB_WE1] = we1_ni;
  end

  strobe_sync #(
    .N      (STB_NUM),
    .N_EDGE (STB_CAS + 1),
    .LVL_LO (STB_CAS),
    .STAGES (STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw),
    .level_o (lvl),
    .fall_o  (fall)
  );

  addr_capture #(
    .BUS_W  (BUS_W),
    .STAGES (STAGES)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_i      (maddr_i),
    .row_fall_i (fall[STB_RAS]),
    .col_fall_i (fall[STB_CAS]),
    .addr_o     (sram_addr_o)
  );

  lane_ctrl u_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cas_i  (lvl[STB_CAS]),
    .we0_i  (lvl[STB_WE0]),
    .we1_i  (lvl[STB_WE1]),
    .ctl_o  (ctl)
  );

  assign sram_we_no = ctl.we_n;
  assign sram_oe_no = ctl.oe_n;
  assign sram_lb_no = ctl.lb_n;
  assign sram_ub_no = ctl.ub_n;
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int unsigned BUS_W = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [BUS_W-1:0]   maddr_i,
  input logic               ras_ni,
  input logic               cas_ni,
  input logic               we0_ni,
  input logic               we1_ni,
  input logic [2*BUS_W-1:0] sram_addr_o,
  input logic               sram_we_no,
  input logic               sram_oe_no,
  input logic               sram_lb_no,
  input logic               sram_ub_no
);
  logic [2:0] cyc_q;
  logic       warm, ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end
  assign warm  = cyc_q >= 3'd1;
  assign ready = cyc_q >= 3'd5;

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (sram_we_no && sram_oe_no && sram_lb_no && sram_ub_no && sram_addr_o == '0)
        else $error("outputs not idle in reset");
    end
  end

  // R2
  row_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && $past(ras_ni, 4) && !$past(ras_ni, 3)) |-> sram_addr_o[2*BUS_W-1:BUS_W] == $past(maddr_i, 3));

  // R2
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !($past(ras_ni, 4) && !$past(ras_ni, 3))) |-> $stable(sram_addr_o[2*BUS_W-1:BUS_W]));

  // R3
  col_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && $past(cas_ni, 4) && !$past(cas_ni, 3)) |-> sram_addr_o[BUS_W-1:0] == $past(maddr_i, 3));

  // R3
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !($past(cas_ni, 4) && !$past(cas_ni, 3))) |-> $stable(sram_addr_o[BUS_W-1:0]));

  // R4
  we_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> sram_we_no == ($past(we0_ni, 3) && $past(we1_ni, 3)));

  // R5
  oe_invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> sram_oe_no != sram_we_no);

  // R6
  write_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !sram_we_no) |-> (sram_lb_no == $past(we0_ni, 3) && sram_ub_no == $past(we1_ni, 3)));

  // R7
  read_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && sram_we_no) |-> (sram_lb_no == $past(cas_ni, 3) && sram_ub_no == !$past(cas_ni, 3)));

  // R7
  one_lane_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && sram_we_no) |-> $countones({sram_lb_no, sram_ub_no}) == 1);
endmodule

bind dram_sram_bridge bridge_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .maddr_i     (maddr_i),
  .ras_ni      (ras_ni),
  .cas_ni      (cas_ni),
  .we0_ni      (we0_ni),
  .we1_ni      (we1_ni),
  .sram_addr_o (sram_addr_o),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no),
  .sram_lb_no  (sram_lb_no),
  .sram_ub_no  (sram_ub_no)
);

// File: tb/dram_sram_bridge_test.sv
module dram_sram_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [8:0]  maddr_i;
  logic        ras_ni, cas_ni, we0_ni, we1_ni;
  logic [17:0] sram_addr_o;
  logic        sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no;

  int errs = 0;
  int checks = 0;
  logic [17:0] exp_addr;

  always #2 clk_i = ~clk_i;

  dram_sram_bridge uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .maddr_i     (maddr_i),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .we0_ni      (we0_ni),
    .we1_ni      (we1_ni),
    .sram_addr_o (sram_addr_o),
    .sram_we_no  (sram_we_no),
    .sram_oe_no  (sram_oe_no),
    .sram_lb_no  (sram_lb_no),
    .sram_ub_no  (sram_ub_no)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // {we_n, oe_n, lb_n, ub_n}
  function automatic logic [3:0] exp_ctl(input logic w0, input logic w1, input logic cs);
    logic wr_idle;
    wr_idle = w0 & w1;
    if (wr_idle) return {1'b1, 1'b0, cs, ~cs};
    return {1'b0, 1'b1, w0, w1};
  endfunction

  function automatic logic [3:0] act_ctl();
    return {sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no};
  endfunction

  // mode: 0 read only, 1 bank0 write, 2 bank1 write, 3 both banks
  task automatic access(input logic [8:0] row, input logic [8:0] col, input logic [1:0] mode);
    maddr_i = row;
    @(negedge clk_i);
    ras_ni = 1'b0;
    settle();
    exp_addr[17:9] = row;
    chk("R2 row load", sram_addr_o, exp_addr);
    maddr_i = col;
    @(negedge clk_i);
    cas_ni = 1'b0;
    settle();
    exp_addr[8:0] = col;
    chk("R3 column load", sram_addr_o, exp_addr);
    chk("R7 read lower phase", act_ctl(), exp_ctl(1'b1, 1'b1, 1'b0));
    if (mode != 2'd0) begin
      we0_ni = ~mode[0];
      we1_ni = ~mode[1];
      settle();
      chk("R6 write lanes", act_ctl(), exp_ctl(we0_ni, we1_ni, 1'b0));
      chk("R4 merged write enable", sram_we_no, 1'b0);
      chk("R5 output enable off in write", sram_oe_no, 1'b1);
      we0_ni = 1'b1;
      we1_ni = 1'b1;
      settle();
      chk("R4 write enable released", sram_we_no, 1'b1);
    end
    maddr_i = 9'($urandom);
    settle();
    chk("R3 bus change ignored", sram_addr_o, exp_addr);
    cas_ni = 1'b1;
    settle();
    chk("R7 read upper phase", act_ctl(), exp_ctl(1'b1, 1'b1, 1'b1));
    chk("R3 cas rise keeps address", sram_addr_o, exp_addr);
    ras_ni = 1'b1;
    settle();
    chk("R2 ras rise keeps address", sram_addr_o, exp_addr);
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni   = 1'b0;
    maddr_i  = 9'h155;
    ras_ni   = 1'b1;
    cas_ni   = 1'b1;
    we0_ni   = 1'b1;
    we1_ni   = 1'b1;
    exp_addr = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset controls", act_ctl(), 4'hF);
    chk("R1 reset address", sram_addr_o, 18'h0);
    rst_ni = 1'b1;
    settle();
    chk("R5 idle read enable", act_ctl(), exp_ctl(1'b1, 1'b1, 1'b1));
    chk("R3 address stays zero", sram_addr_o, 18'h0);

    access(9'h1FF, 9'h000, 2'd0);
    access(9'h000, 9'h1FF, 2'd3);
    access(9'h0AA, 9'h155, 2'd1);
    access(9'h155, 9'h0AA, 2'd2);

    for (int n = 0; n < 120; n++) begin
      access(9'($urandom), 9'($urandom), 2'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule